// File: doc/BRIEF.md
# Multislope Integrate Phase Sequencer

This block runs the integrate phase of a multislope integrating converter. A clock-enable `tick` marks one count period. After a `start` pulse the block walks through ten intervals: a short opening interval, a run of normal intervals, and a lengthened closing interval. Each interval begins with one count in which only the input is integrated and the comparator is sampled. One balancing count follows, which keeps the positive and negative pulse totals even. The rest of the interval applies the reference chosen by the comparator sample.

Throughout the phase the input-integrate enable is held high and the auto-zero and deintegrate-reference enables are held low. The two reference enables are never high together. The block keeps tallies of the count periods and pulses for each reference polarity. When the phase completes it raises a one-cycle done strobe, and the tallies stay frozen so a later deintegrate stage can read them.

Top module: `integ_phase_seq`

## Requirements
- R1: While `rst` is high at a clock edge, every enable output, `done`, `imbalance` and all four tallies are cleared to zero.
- R2: A `start` seen while idle raises `intEn` on the next clock edge. `intEn` stays high until the edge that raises `done`. A `start` during a running phase has no effect on the sequence or its timing, and a `tick` while idle changes no output.
- R3: `posRefEn` and `negRefEn` are never high together, and both are low whenever `intEn` is low. `azEn` and `deintRefEn` are always low.
- R4: On the first count of every interval both reference enables are low. `cmp` is captured at that count's tick edge only, and its value at any other tick has no effect.
- R5: The second count of every interval is a balancing pulse. It is negative if the positive pulse tally exceeds the negative one, and positive if it is smaller. When the tallies are equal it takes the polarity opposite to the comparator-chosen one.
- R6: The comparator-chosen segment runs from the third count to the end of the interval, or to count 31 in the closing interval. It is positive when the captured `cmp` was 1 and negative when it was 0.
- R7: Interval lengths are 16 counts, then 8 intervals of 32 counts, then 35 counts, for 307 counts in all. `done` is high for exactly one clock cycle, starting at the edge of the 308th tick after start.
- R8: In counts 32 to 34 of the closing interval, counts 32 and 34 carry a pulse toward the lagging polarity if the pulse tallies differ and stay idle otherwise. Count 33 is always idle.
- R9: `posCounts` and `negCounts` equal the number of counts during which each reference was on. For the default parameters their sum at `done` is 294.
- R10: Each balancing pulse and each comparator-chosen segment adds one to its polarity's pulse tally. At `done` the two pulse tallies are equal (10 each by default) and `imbalance` is low. A new `start` clears every tally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Count-period clock enable |
| start | input | 1 | Begins the phase when idle |
| cmp | input | 1 | Integrator comparator output |
| posRefEn | output | 1 | Positive reference switch enable |
| negRefEn | output | 1 | Negative reference switch enable |
| intEn | output | 1 | Input-integrate enable |
| azEn | output | 1 | Auto-zero enable (held low) |
| deintRefEn | output | 1 | Deintegrate reference enable (held low) |
| done | output | 1 | One-cycle end-of-phase strobe |
| posCounts | output | CNT_W | Count periods with positive reference |
| negCounts | output | CNT_W | Count periods with negative reference |
| posPulses | output | PUL_W | Positive pulse tally |
| negPulses | output | PUL_W | Negative pulse tally |
| imbalance | output | 1 | Pulse tallies unequal at end |

## Verification
Every reference enable and tally is registered on the clock edge where `tick` is high. The slot a tick executes is therefore visible from that edge onward. `intEn` rises one edge after `start`. `done` rises on the edge of the tick that follows the final count, and drops on the next edge. The bench pulses `tick` for one cycle at a falling edge and compares outputs at the following falling edge. It checks `done` again one cycle later, so each comparison lands mid-cycle after exactly one register stage. Its expected slot pattern comes from a tally model driven by the same comparator values, and `cmp` is inverted on every tick other than the sampling one.

// File: rtl/integ_seq_pkg.sv
package integ_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } seqState_t;

  // strobes from control to datapath, valid for one clock
  typedef struct packed {
    logic clrAll;
    logic slotGo;
    logic sampleCmp;
    logic balSlot;
    logic chosenSlot;
    logic chosenFirst;
    logic tailSlot;
    logic finish;
  } ctrlStrobes_t;

endpackage

// File: rtl/integ_seq_ctrl.sv
module integ_seq_ctrl
  import integ_seq_pkg::*;
#(
  parameter int FIRST_LEN = 16,
  parameter int NORM_LEN  = 32,
  parameter int NUM_NORM  = 8,
  parameter int TAIL_LEN  = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         start,
  output ctrlStrobes_t strb,
  output logic         running
);

  localparam int LAST_IV = NUM_NORM + 1;
  localparam int IW      = $clog2(LAST_IV + 1);
  localparam int SW      = $clog2(NORM_LEN + TAIL_LEN + 1);
  localparam logic [SW-1:0] FIRST_L  = SW'(FIRST_LEN);
  localparam logic [SW-1:0] NORM_L   = SW'(NORM_LEN);
  localparam logic [SW-1:0] FINAL_L  = SW'(NORM_LEN + TAIL_LEN);
  localparam logic [IW-1:0] LAST_IDX = IW'(LAST_IV);

  seqState_t     state;
  logic [IW-1:0] ivIdx;
  logic [SW-1:0] slotIdx;
  logic [SW-1:0] curLen;
  logic [SW-1:0] chosenEnd;
  logic [SW-1:0] tailOfs;
  logic          lastIv;
  logic          lastSlot;

  always_comb begin
    lastIv = (ivIdx == LAST_IDX);
    if (ivIdx == '0)   curLen = FIRST_L;
    else if (lastIv)   curLen = FINAL_L;
    else               curLen = NORM_L;
    chosenEnd = lastIv ? NORM_L : curLen;
    lastSlot  = (slotIdx == curLen - SW'(1));
    tailOfs   = slotIdx - NORM_L;
  end

  always_comb begin
    strb = '0;
    strb.clrAll = (state == ST_IDLE) && start;
    if (state == ST_RUN && tick) begin
      strb.slotGo      = 1'b1;
      strb.sampleCmp   = (slotIdx == '0);
      strb.balSlot     = (slotIdx == SW'(1));
      strb.chosenSlot  = (slotIdx >= SW'(2)) && (slotIdx < chosenEnd);
      strb.chosenFirst = (slotIdx == SW'(2));
      strb.tailSlot    = lastIv && (slotIdx >= NORM_L) && !tailOfs[0];
    end else if (state == ST_FIN && tick) begin
      strb.slotGo = 1'b1;
      strb.finish = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      ivIdx   <= '0;
      slotIdx <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          state   <= ST_RUN;
          ivIdx   <= '0;
          slotIdx <= '0;
        end
        ST_RUN: if (tick) begin
          if (lastSlot) begin
            slotIdx <= '0;
            if (lastIv) state <= ST_FIN;
            else        ivIdx <= ivIdx + IW'(1);
          end else begin
            slotIdx <= slotIdx + SW'(1);
          end
        end
        ST_FIN: if (tick) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign running = (state != ST_IDLE);

  AST_START_ENTERS_RUN: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && start) |=> (state == ST_RUN && slotIdx == '0 && ivIdx == '0)); // R2
  AST_RUN_HOLDS_NO_TICK: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN && !tick) |=> (state == ST_RUN && $stable(slotIdx) && $stable(ivIdx))); // R2

endmodule

// File: rtl/integ_seq_datapath.sv
module integ_seq_datapath
  import integ_seq_pkg::*;
#(
  parameter int CNT_W = 10,
  parameter int PUL_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  ctrlStrobes_t     strb,
  input  logic             cmp,
  output logic             posRef,
  output logic             negRef,
  output logic             done,
  output logic [CNT_W-1:0] posCnt,
  output logic [CNT_W-1:0] negCnt,
  output logic [PUL_W-1:0] posPul,
  output logic [PUL_W-1:0] negPul,
  output logic             imbal
);

  logic cmpHeld;
  logic pulEqual;
  logic posLags;
  logic balPos;
  logic nextPos;
  logic nextNeg;
  logic newPulse;

  always_comb begin
    pulEqual = (posPul == negPul);
    posLags  = (posPul < negPul);
    // tie: go against the comparator choice so the interval stays even
    balPos   = posLags || (pulEqual && !cmpHeld);
    nextPos  = 1'b0;
    nextNeg  = 1'b0;
    newPulse = 1'b0;
    if (strb.balSlot) begin
      nextPos  = balPos;
      nextNeg  = !balPos;
      newPulse = 1'b1;
    end else if (strb.chosenSlot) begin
      nextPos  = cmpHeld;
      nextNeg  = !cmpHeld;
      newPulse = strb.chosenFirst;
    end else if (strb.tailSlot && !pulEqual) begin
      nextPos  = posLags;
      nextNeg  = !posLags;
      newPulse = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmpHeld <= 1'b0;
      posRef  <= 1'b0;
      negRef  <= 1'b0;
      done    <= 1'b0;
      posCnt  <= '0;
      negCnt  <= '0;
      posPul  <= '0;
      negPul  <= '0;
      imbal   <= 1'b0;
    end else begin
      done <= strb.finish;
      if (strb.clrAll) begin
        posCnt <= '0;
        negCnt <= '0;
        posPul <= '0;
        negPul <= '0;
        imbal  <= 1'b0;
      end
      if (strb.sampleCmp) cmpHeld <= cmp;
      if (strb.slotGo) begin
        posRef <= nextPos;
        negRef <= nextNeg;
        if (nextPos) posCnt <= posCnt + CNT_W'(1);
        if (nextNeg) negCnt <= negCnt + CNT_W'(1);
        if (newPulse && nextPos) posPul <= posPul + PUL_W'(1);
        if (newPulse && nextNeg) negPul <= negPul + PUL_W'(1);
      end
      if (strb.finish) imbal <= !pulEqual;
    end
  end

  AST_REFS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(posRef && negRef)); // R3
  AST_REFS_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
    !strb.slotGo |=> ($stable(posRef) && $stable(negRef))); // R11
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R7
  AST_BALANCED_AT_DONE: assert property (@(posedge clk) disable iff (rst)
    done |-> (posPul == negPul && !imbal)); // R10
  AST_INPUT_ONLY_SLOT: assert property (@(posedge clk) disable iff (rst)
    strb.sampleCmp |=> (!posRef && !negRef)); // R4

endmodule

// File: rtl/integ_phase_seq.sv
module integ_phase_seq
  import integ_seq_pkg::*;
#(
  parameter int FIRST_LEN = 16,
  parameter int NORM_LEN  = 32,
  parameter int NUM_NORM  = 8,
  parameter int TAIL_LEN  = 3,
  parameter int CNT_W     = 10,
  parameter int PUL_W     = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             start,
  input  logic             cmp,
  output logic             posRefEn,
  output logic             negRefEn,
  output logic             intEn,
  output logic             azEn,
  output logic             deintRefEn,
  output logic             done,
  output logic [CNT_W-1:0] posCounts,
  output logic [CNT_W-1:0] negCounts,
  output logic [PUL_W-1:0] posPulses,
  output logic [PUL_W-1:0] negPulses,
  output logic             imbalance
);

  ctrlStrobes_t strb;

  integ_seq_ctrl #(
    .FIRST_LEN(FIRST_LEN), .NORM_LEN(NORM_LEN),
    .NUM_NORM(NUM_NORM), .TAIL_LEN(TAIL_LEN)
  ) uCtrl (
    .clk(clk), .rst(rst), .tick(tick), .start(start),
    .strb(strb), .running(intEn)
  );

  integ_seq_datapath #(.CNT_W(CNT_W), .PUL_W(PUL_W)) uDp (
    .clk(clk), .rst(rst), .strb(strb), .cmp(cmp),
    .posRef(posRefEn), .negRef(negRefEn), .done(done),
    .posCnt(posCounts), .negCnt(negCounts),
    .posPul(posPulses), .negPul(negPulses), .imbal(imbalance)
  );

  assign azEn       = 1'b0;
  assign deintRefEn = 1'b0;

  AST_IDLE_REFS_OFF: assert property (@(posedge clk) disable iff (rst)
    !intEn |-> (!posRefEn && !negRefEn)); // R3
  AST_DONE_ENDS_RUN: assert property (@(posedge clk) disable iff (rst)
    done |-> !intEn); // R7

endmodule

// File: tb/integ_phase_seq_test.sv
`timescale 1ns/1ps
module integ_phase_seq_test;

  localparam int NUM_IV = 10;

  logic clk = 1'b0;
  logic rst, tick, start, cmp;
  logic posRefEn, negRefEn, intEn, azEn, deintRefEn, done, imbalance;
  logic [9:0] posCounts, negCounts;
  logic [5:0] posPulses, negPulses;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  integ_phase_seq uut (
    .clk(clk), .rst(rst), .tick(tick), .start(start), .cmp(cmp),
    .posRefEn(posRefEn), .negRefEn(negRefEn), .intEn(intEn), .azEn(azEn),
    .deintRefEn(deintRefEn), .done(done), .posCounts(posCounts),
    .negCounts(negCounts), .posPulses(posPulses), .negPulses(negPulses),
    .imbalance(imbalance)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit cmpFor(input int sel, input int iv);
    case (sel)
      0: return 1'b1;
      1: return 1'b0;
      2: return iv[0];
      default: return ((iv * 5 + 3) % 7) > 2;
    endcase
  endfunction

  task automatic doTick(input bit c);
    @(negedge clk);
    cmp  = c;
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic pulseStart();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic testReset();
    rst = 1'b1; tick = 1'b0; start = 1'b0; cmp = 1'b0;
    repeat (3) @(negedge clk);
    check(!posRefEn && !negRefEn && !intEn && !done && !imbalance, "R1 enables", 
          {posRefEn, negRefEn, intEn, done}, 0);
    check(posCounts == 0 && negCounts == 0 && posPulses == 0 && negPulses == 0,
          "R1 tallies", posCounts + negCounts + posPulses + negPulses, 0);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic testIdleTick();
    doTick(1'b1);
    doTick(1'b0);
    check(!intEn && !posRefEn && !negRefEn, "R2 tick ignored while idle",
          {intEn, posRefEn, negRefEn}, 0);
  endtask

  // full phase with a model of the slot pattern
  task automatic runPhase(input int sel, input bit midStart);
    int mp = 0, mn = 0, mpc = 0, mnc = 0;
    bit held = 1'b0;
    bit slotOk = 1'b1;
    pulseStart();
    check(intEn == 1'b1, "R2 intEn after start", intEn, 1);
    check(posCounts == 0 && posPulses == 0, "R10 start clears tallies", posCounts, 0);
    for (int iv = 0; iv < NUM_IV; iv++) begin
      int len = (iv == 0) ? 16 : ((iv == NUM_IV - 1) ? 35 : 32);
      bit cv = cmpFor(sel, iv);
      for (int s = 0; s < len; s++) begin
        bit ep = 1'b0, en = 1'b0;
        string tag;
        if (s == 0) begin
          held = cv; tag = "R4 input-only count";
        end else if (s == 1) begin
          bit bp = (mp < mn) || (mp == mn && !held);
          ep = bp; en = !bp; tag = "R5 balancing count";
          if (bp) mp++; else mn++;
        end else if (s < 32) begin
          ep = held; en = !held; tag = "R6 chosen segment";
          if (s == 2) begin if (held) mp++; else mn++; end
        end else begin
          tag = "R8 tail count";
          if (s != 33 && mp != mn) begin
            ep = (mp < mn); en = !ep;
            if (ep) mp++; else mn++;
          end
        end
        if (ep) mpc++;
        if (en) mnc++;
        if (midStart && iv == 4 && s == 5) pulseStart();
        doTick(s == 0 ? cv : !cv);
        if (posRefEn !== ep || negRefEn !== en || intEn !== 1'b1 || done !== 1'b0
            || azEn !== 1'b0 || deintRefEn !== 1'b0) begin
          slotOk = 1'b0;
          check(1'b0, tag, {posRefEn, negRefEn, intEn, done}, {ep, en, 1'b1, 1'b0});
        end
      end
    end
    check(slotOk, "R3 R4 R5 R6 R8 slot pattern", slotOk, 1);
    doTick(1'b0);
    check(done == 1'b1, "R7 done at tick 308", done, 1);
    check(intEn == 1'b0 && !posRefEn && !negRefEn, "R2 intEn ends with done",
          {intEn, posRefEn, negRefEn}, 0);
    check(posCounts == mpc && negCounts == mnc, "R9 count tallies",
          posCounts * 1000 + negCounts, mpc * 1000 + mnc);
    check(posCounts + negCounts == 294, "R9 total counts", posCounts + negCounts, 294);
    check(posPulses == mp && negPulses == mn && mp == 10, "R10 pulse tallies",
          posPulses * 100 + negPulses, mp * 100 + mn);
    check(imbalance == 1'b0, "R10 imbalance low", imbalance, 0);
    @(negedge clk);
    check(done == 1'b0, "R7 done one cycle", done, 0);
    doTick(1'b1);
    check(posCounts == mpc && !intEn, "R2 tallies held after done", posCounts, mpc);
  endtask

  task automatic testMidReset();
    pulseStart();
    for (int s = 0; s < 5; s++) doTick(1'b1);
    check(posRefEn == 1'b1, "R6 positive segment before reset", posRefEn, 1);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(!posRefEn && !negRefEn && !intEn && posCounts == 0 && posPulses == 0 && negPulses == 0,
          "R1 reset mid-phase", {posRefEn, negRefEn, intEn}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    testReset();
    testIdleTick();
    runPhase(0, 1'b0);
    runPhase(1, 1'b0);
    runPhase(2, 1'b1);
    runPhase(3, 1'b0);
    testMidReset();
    runPhase(3, 1'b1);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule